// File: doc/BRIEF.md
# Iterative Pair-by-Byte Divider

This block divides a 16-bit dividend, presented as a high byte and a low byte, by an 8-bit divisor. It produces an 8-bit quotient and an 8-bit remainder, and it updates four status flags inside an 8-bit flag byte. The arithmetic is a fixed nine-pass rotate, compare and subtract loop. The loop runs on a 17-bit working register, and the divisor is aligned nine places to the left. Every input has a defined result, including a quotient that does not fit in eight bits and a zero divisor. Those two cases give nonstandard values that must match the loop exactly. No trap or error is raised.

An operation is offered on a valid/ready pair. The divider accepts it on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` stays low while an operation is running, so any offer made during that time is neither taken nor stored. The caller must hold its operands until the edge at which they are taken. The result side has no back-pressure. `out_valid` is high for one cycle, and the caller must capture the result in that cycle. The result outputs then keep their values until the next result. A new operation can be accepted in the same cycle that a result is presented.

Top module: `ya_div_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` falls on the edge that accepts an operation and stays 0 until a result is presented. An `in_valid` offered while `in_ready` is 0 is ignored: it does not change the pending result or start another operation.
- R2: Take the edge that accepts an operation as edge 0. `out_valid` rises on edge 10 and falls on edge 11. `in_ready` is back at 1 in the same cycle that `out_valid` is high.
- R3: When the high byte is less than the divisor, `out_quot` is floor(dividend / divisor) and `out_rem` is the remainder.
- R4: For any operands, the results match this loop. W starts as {0, hi, lo} in 17 bits, and D is {div, 9'b0}. Nine passes are run. Each pass rotates W left by one bit, with bit 16 moving into bit 0. If W ≥ D after the rotate, bit 0 is inverted. If bit 0 is then 1, D is subtracted from W, modulo 2^17. After the nine passes, `out_quot` = W[7:0] and `out_rem` = W[16:9].
- R5: Flag bit 6 (V) of `out_flags` equals W[8] of the final loop value.
- R6: Flag bit 3 (H) of `out_flags` is 1 exactly when div[3:0] ≤ hi[3:0], using the operands that were accepted.
- R7: Flag bit 1 (Z) is 1 exactly when `out_quot` is zero. Flag bit 7 (N) equals `out_quot[7]`.
- R8: Flag bits 5, 4, 2 and 0 of `out_flags` are copied from `in_flags` as it was on the accepting edge.
- R9: If reset is asserted while an operation is running, that operation is abandoned. No `out_valid` follows, and `in_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The divider can take an operation |
| in_hi | input | 8 | High byte of the dividend |
| in_lo | input | 8 | Low byte of the dividend |
| in_div | input | 8 | Divisor |
| in_flags | input | 8 | Flag byte to be updated |
| out_valid | output | 1 | One-cycle result strobe |
| out_quot | output | 8 | Quotient (loop bits 7:0) |
| out_rem | output | 8 | Remainder (loop bits 16:9) |
| out_flags | output | 8 | Flag byte with N, V, H and Z updated |

## Verification
Two events can fall in the same cycle: a result is presented and the next operation is accepted. This works because `in_ready` recovers while `out_valid` is high. The bench drives a second offer during that strobe cycle. It then checks that the first result is correct in that cycle. It also checks that the second result arrives exactly ten edges later with its own values. The pending result must not be disturbed by the overlap, and the new operation must not be lost.

// File: rtl/ya_div_pkg.sv
package ya_div_pkg;
  // positions of the flags this block writes, inside the flag byte
  localparam int FLAG_W = 8;
  localparam int FB_N   = 7;
  localparam int FB_V   = 6;
  localparam int FB_H   = 3;
  localparam int FB_Z   = 1;
  localparam logic [FLAG_W-1:0] OWN_MASK =
    (8'd1 << FB_N) | (8'd1 << FB_V) | (8'd1 << FB_H) | (8'd1 << FB_Z);
  localparam logic [FLAG_W-1:0] PASS_MASK = ~OWN_MASK;
endpackage

// File: rtl/ya_div_step.sv
module ya_div_step #(
  parameter int DW = 8,
  localparam int WW = 2*DW + 1
) (
  input  logic [WW-1:0] cur,
  input  logic [WW-1:0] cmp,
  output logic [WW-1:0] nxt
);
  logic [WW-1:0] rot;
  logic [WW-1:0] mark;

  always_comb begin
    rot  = {cur[WW-2:0], cur[WW-1]};
    mark = rot;
    if (rot >= cmp) mark[0] = ~rot[0];
    if (mark[0]) nxt = mark - cmp;
    else         nxt = mark;
  end
endmodule

// File: rtl/ya_div_ctrl.sv
module ya_div_ctrl #(
  parameter int ITERS = 9,
  localparam int CW = $clog2(ITERS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output logic iter_en,
  output logic finish,
  output logic done
);
  logic [CW-1:0] cnt;

  assign finish  = busy && (cnt == CW'(ITERS));
  assign iter_en = busy && (cnt != CW'(ITERS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= CW'(ITERS)));
endmodule

// File: rtl/ya_div_flags.sv
module ya_div_flags
  import ya_div_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2*DW + 1
) (
  input  logic [DW-1:0]     hi,
  input  logic [DW-1:0]     div,
  output logic              half_cmp,
  input  logic [FLAG_W-1:0] base,
  input  logic              half_q,
  input  logic [WW-1:0]     fin,
  output logic [FLAG_W-1:0] merged
);
  logic [DW-1:0] q;

  assign half_cmp = (div[3:0] <= hi[3:0]);
  assign q        = fin[DW-1:0];

  always_comb begin
    merged       = base;
    merged[FB_N] = q[DW-1];
    merged[FB_V] = fin[DW];
    merged[FB_H] = half_q;
    merged[FB_Z] = (q == '0);
  end
endmodule

// File: rtl/ya_div_unit.sv
module ya_div_unit
  import ya_div_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2*DW + 1,
  localparam int ITERS = DW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_hi,
  input  logic [DW-1:0]     in_lo,
  input  logic [DW-1:0]     in_div,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  output logic [DW-1:0]     out_quot,
  output logic [DW-1:0]     out_rem,
  output logic [FLAG_W-1:0] out_flags
);
  logic              busy, iter_en, finish, accept;
  logic [WW-1:0]     work_q, cmp_q, work_n;
  logic [FLAG_W-1:0] base_q, merged;
  logic              half_q, half_cmp;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  ya_div_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
    .iter_en(iter_en), .finish(finish), .done(out_valid)
  );

  ya_div_step #(.DW(DW)) u_step (.cur(work_q), .cmp(cmp_q), .nxt(work_n));

  ya_div_flags #(.DW(DW)) u_flags (
    .hi(in_hi), .div(in_div), .half_cmp(half_cmp),
    .base(base_q), .half_q(half_q), .fin(work_q), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q    <= '0;
      cmp_q     <= '0;
      base_q    <= '0;
      half_q    <= 1'b0;
      out_quot  <= '0;
      out_rem   <= '0;
      out_flags <= '0;
    end else begin
      if (accept) begin
        work_q <= {1'b0, in_hi, in_lo};
        cmp_q  <= {in_div, {(DW+1){1'b0}}};
        base_q <= in_flags;
        half_q <= half_cmp;
      end else if (iter_en) begin
        work_q <= work_n;
      end
      if (finish) begin
        out_quot  <= work_q[DW-1:0];
        out_rem   <= work_q[WW-1:DW+1];
        out_flags <= merged;
      end
    end
  end

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[FB_Z] == (out_quot == '0)));
  // R7
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[FB_N] == out_quot[DW-1]));
  // R8
  pass_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_flags & PASS_MASK) == (base_q & PASS_MASK)));
  // R2
  ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

// File: tb/ya_div_unit_tb.sv
`timescale 1ns/1ps
module ya_div_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid;
  logic [7:0] in_hi = '0, in_lo = '0, in_div = '0, in_flags = '0;
  logic [7:0] out_quot, out_rem, out_flags;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ya_div_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hi(in_hi), .in_lo(in_lo), .in_div(in_div), .in_flags(in_flags),
    .out_valid(out_valid), .out_quot(out_quot), .out_rem(out_rem),
    .out_flags(out_flags)
  );

  // {hi, lo, div, exp_quot, exp_rem, hand_checked}
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {8'h00, 8'h64, 8'h07, 8'h0E, 8'h02, 1'b1},
    {8'h00, 8'hFF, 8'h10, 8'h0F, 8'h0F, 1'b1},
    {8'h0F, 8'hFF, 8'h10, 8'hFF, 8'h0F, 1'b1},
    {8'h12, 8'h34, 8'h56, 8'h36, 8'h10, 1'b1},
    {8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b1},
    {8'h80, 8'hFF, 8'hFF, 8'h81, 8'h80, 1'b1},
    {8'h12, 8'h34, 8'h05, 8'h00, 8'h00, 1'b0},
    {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
    {8'hFF, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0}
  };

  function automatic logic [16:0] loop_model(input logic [7:0] y, a, x);
    logic [16:0] w, d;
    w = {1'b0, y, a};
    d = {x, 9'b0};
    for (int i = 0; i < 9; i++) begin
      w = {w[15:0], w[16]};
      if (w >= d) w[0] = ~w[0];
      if (w[0]) w = w - d;
    end
    return w;
  endfunction

  function automatic logic [7:0] flag_model(input logic [7:0] f, y, x,
                                            input logic [16:0] w);
    logic [7:0] r;
    r = f;
    r[7] = w[7];
    r[6] = w[8];
    r[3] = (x[3:0] <= y[3:0]);
    r[1] = (w[7:0] == 8'h00);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // offer at a negedge; acceptance happens at the following posedge
  task automatic offer(input logic [7:0] y, a, x, f);
    in_hi = y; in_lo = a; in_div = x; in_flags = f; in_valid = 1'b1;
  endtask

  // called at the negedge just after the accepting posedge; returns at the
  // negedge where out_valid must be high
  task automatic wait_result(input string tag, input bit poke);
    for (int n = 1; n <= 10; n++) begin
      if (n == 1) in_valid = 1'b0;
      if (poke && n == 3) offer(8'h00, 8'h09, 8'h03, 8'h00);
      if (poke && n == 5) in_valid = 1'b0;
      check(out_valid == 1'b0, {tag, " R2 early strobe"}, 16'(out_valid), 16'd0);
      check(in_ready == 1'b0, {tag, " R1 ready while running"}, 16'(in_ready), 16'd0);
      @(negedge clk);
    end
    check(out_valid == 1'b1, {tag, " R2 strobe on edge 10"}, 16'(out_valid), 16'd1);
    check(in_ready == 1'b1, {tag, " R2 ready with strobe"}, 16'(in_ready), 16'd1);
  endtask

  task automatic judge(input string tag, input logic [7:0] y, a, x, f,
                       input logic [7:0] eq, er, input bit hand);
    logic [16:0] w;
    w = loop_model(y, a, x);
    if (hand) begin
      check(out_quot == eq, {tag, " R3 quotient"}, 16'(out_quot), 16'(eq));
      check(out_rem == er, {tag, " R3 remainder"}, 16'(out_rem), 16'(er));
    end
    check(out_quot == w[7:0], {tag, " R4 quotient"}, 16'(out_quot), 16'(w[7:0]));
    check(out_rem == w[16:9], {tag, " R4 remainder"}, 16'(out_rem), 16'(w[16:9]));
    check(out_flags[6] == w[8], {tag, " R5 V"}, 16'(out_flags[6]), 16'(w[8]));
    check(out_flags[3] == (x[3:0] <= y[3:0]), {tag, " R6 H"},
          16'(out_flags[3]), 16'(x[3:0] <= y[3:0]));
    check(out_flags[1] == (w[7:0] == 0) && out_flags[7] == w[7], {tag, " R7 Z/N"},
          16'(out_flags), 16'(flag_model(f, y, x, w)));
    check((out_flags & 8'h35) == (f & 8'h35), {tag, " R8 passthrough"},
          16'(out_flags & 8'h35), 16'(f & 8'h35));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1 reset in_ready", 16'(in_ready), 16'd1);
    check(out_valid == 1'b0, "R1 reset out_valid", 16'(out_valid), 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] f;
      f = 8'(8'hA5 ^ (i * 8'h1B));
      offer(VEC[i][40:33], VEC[i][32:25], VEC[i][24:17], f);
      @(negedge clk);
      wait_result($sformatf("vec%0d", i), 1'b0);
      judge($sformatf("vec%0d", i), VEC[i][40:33], VEC[i][32:25], VEC[i][24:17],
            f, VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
      @(negedge clk);
    end

    // R1: offer while running is ignored
    offer(8'h00, 8'h64, 8'h07, 8'h5A);
    @(negedge clk);
    wait_result("ignore", 1'b1);
    judge("ignore R1", 8'h00, 8'h64, 8'h07, 8'h5A, 8'h0E, 8'h02, 1'b1);
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 no extra operation", 16'(out_valid), 16'd0);
    end

    // R2: back-to-back, new offer in the strobe cycle
    offer(8'h12, 8'h34, 8'h56, 8'h11);
    @(negedge clk);
    wait_result("b2b first", 1'b0);
    judge("b2b first", 8'h12, 8'h34, 8'h56, 8'h11, 8'h36, 8'h10, 1'b1);
    offer(8'h00, 8'hFF, 8'h10, 8'hEE);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 strobe falls on edge 11", 16'(out_valid), 16'd0);
    wait_result("b2b second", 1'b0);
    judge("b2b second", 8'h00, 8'hFF, 8'h10, 8'hEE, 8'h0F, 8'h0F, 1'b1);
    @(negedge clk);

    // R9: reset mid-run abandons the operation
    offer(8'h00, 8'h64, 8'h07, 8'h00);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 ready after abort", 16'(in_ready), 16'd1);
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 no strobe after abort", 16'(out_valid), 16'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule